// File: doc/BRIEF.md
# SPI Register Access Slave

This block is a four-wire SPI slave that lets a host microcontroller read and write a bank of 64 byte-wide registers. The host pulls the select line low, sends one command byte, and then clocks any number of data bytes in or out. The command byte carries the transfer direction, an auto-increment flag and a 6-bit register address. The transfer stays open until the host releases the select line, so a single select window can cover one register or a long burst.

The SPI pins are asynchronous to the block clock. Each pin passes through a two-flop synchroniser, and the SCK edges are then found in the clock domain, so the system clock must run well above the serial clock. Two locations are read-only. Address 0x00 returns a fixed identification byte. Address 0x1D returns a wake-pending flag that a clock-domain pulse sets and that a read clears. The contents of all registers are presented on a flat output bus for the surrounding logic.

Top module: `spi_regfile`

## Requirements
- R1: The SPI interface uses mode 0. MOSI is sampled on rising SCK, most significant bit first, and a byte is taken only while ss_n is low.
- R2: In the first byte after ss_n falls, bit 7 selects the direction (1 = write, 0 = read), bit 6 is the increment flag, and bits 5:0 are the register address.
- R3: Each complete data byte of a write transaction is stored at the current address if that address is writable, and the stored value then appears on regs_o at bits [8*a+7 : 8*a].
- R4: In a read transaction, MISO carries the current register MSB first, starting with the first data byte after the command. MISO is low while ss_n is high.
- R5: With the increment flag at 1, the address advances by one after every data byte and wraps from 0x3F to 0x00. With the flag at 0, every data byte uses the same address.
- R6: A burst continues for any number of data bytes until ss_n rises, and each new transaction starts again with a command byte.
- R7: Address 0x00 reads as ID_VALUE (default 0xA5). Address 0x1D reads as {7'b0, wake pending}. Writes to both addresses are ignored.
- R8: A one-cycle wake_evt pulse sets the wake-pending flag. The flag clears whenever address 0x1D is loaded for shifting out in a read. This includes the look-ahead load made at the end of each byte of a read. If a set and a clear happen in the same cycle, the set wins.
- R9: A byte cut short by ss_n rising has no effect on the registers.
- R10: After reset, all writable registers are 0x00 and the wake-pending flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, much faster than SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| ss_n | input | 1 | Active-low select from the host |
| miso | output | 1 | Serial data to the host |
| wake_evt | input | 1 | One-cycle pulse that sets the wake-pending flag |
| regs_o | output | 512 | All 64 registers, location a at bits [8*a+7:8*a] |

## Verification
The assertions assume that SCK, MOSI and ss_n change slowly enough for the synchronisers to present every level for several clock cycles. They also assume that MOSI is stable around each rising SCK and that ss_n moves only while SCK is low. The stimulus holds each SCK phase for eight clock cycles. It changes MOSI and ss_n only in the low phase, and it leaves idle cycles around every select edge. The assertions also expect wake_evt to be a clock-domain signal, so the bench drives it for a single cycle on the falling clock edge.

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int              AW        = 6,
  parameter logic [7:0]      ID_VALUE  = 8'hA5,
  parameter logic [AW-1:0]   WAKE_ADDR = AW'(29)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sck,
  input  logic                     mosi,
  input  logic                     ss_n,
  output logic                     miso,
  input  logic                     wake_evt,
  output logic [(1<<AW)*(AW+2)-1:0] regs_o
);
  localparam int CW   = AW + 2;
  localparam int DW   = CW;
  localparam int NREG = 1 << AW;
  localparam int BW   = $clog2(CW);
  localparam logic [AW-1:0] ID_ADDR = '0;

  logic [2:0]     sck_s;
  logic [1:0]     mosi_s;
  logic [1:0]     ss_s;
  logic           sel, sck_rise, sck_fall, byte_done;
  logic [CW-1:0]  rx_sh;
  logic [CW-1:0]  rx_byte;
  logic [BW-1:0]  bit_cnt;
  logic           in_data, dir_wr, inc;
  logic [AW-1:0]  addr, load_addr;
  logic [DW-1:0]  tx_sh;
  logic           pend;
  logic           load_rd, wr_en;
  logic [DW-1:0]  mem [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s  <= '0;
      mosi_s <= '0;
      ss_s   <= '1;
    end else begin
      sck_s  <= {sck_s[1:0], sck};
      mosi_s <= {mosi_s[0], mosi};
      ss_s   <= {ss_s[0], ss_n};
    end

  assign sel       = ~ss_s[1];
  assign sck_rise  = sel & sck_s[1] & ~sck_s[2];
  assign sck_fall  = sel & ~sck_s[1] & sck_s[2];
  assign byte_done = sck_rise & (bit_cnt == BW'(CW-1));
  assign rx_byte   = {rx_sh[CW-2:0], mosi_s[1]};

  function automatic logic is_ro(input logic [AW-1:0] a);
    return (a == ID_ADDR) || (a == WAKE_ADDR);
  endfunction

  function automatic logic [DW-1:0] rd_val(input logic [AW-1:0] a);
    if (a == ID_ADDR)        return ID_VALUE;
    else if (a == WAKE_ADDR) return {{(DW-1){1'b0}}, pend};
    else                     return mem[a];
  endfunction

  assign load_addr = in_data ? addr + AW'(inc) : rx_byte[AW-1:0];
  assign load_rd   = byte_done & (in_data ? ~dir_wr : ~rx_byte[CW-1]);
  assign wr_en     = byte_done & in_data & dir_wr & ~is_ro(addr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sh   <= '0;
      bit_cnt <= '0;
      in_data <= 1'b0;
      dir_wr  <= 1'b0;
      inc     <= 1'b0;
      addr    <= '0;
    end else if (!sel) begin
      bit_cnt <= '0;
      in_data <= 1'b0;
    end else if (sck_rise) begin
      rx_sh   <= rx_byte;
      bit_cnt <= bit_cnt + 1'b1;
      if (byte_done) begin
        if (!in_data) begin
          in_data <= 1'b1;
          dir_wr  <= rx_byte[CW-1];
          inc     <= rx_byte[CW-2];
          addr    <= rx_byte[AW-1:0];
        end else begin
          addr    <= addr + AW'(inc);
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          tx_sh <= '0;
    else if (!sel)                       tx_sh <= '0;
    else if (load_rd)                    tx_sh <= rd_val(load_addr);
    else if (sck_fall && bit_cnt != '0)  tx_sh <= {tx_sh[DW-2:0], 1'b0};

  assign miso = tx_sh[DW-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                  pend <= 1'b0;
    else if (wake_evt)                           pend <= 1'b1;
    else if (load_rd && load_addr == WAKE_ADDR)  pend <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr] <= rx_byte;
    end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*DW +: DW] = rd_val(AW'(g));
  end
endmodule

// File: rtl/spi_regfile_chk.sv
module spi_regfile_chk #(
  parameter int            AW        = 6,
  parameter logic [AW-1:0] WAKE_ADDR = AW'(29)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ss_n,
  input logic                      miso,
  input logic                      wake_evt,
  input logic                      pend,
  input logic                      byte_done,
  input logic                      in_data,
  input logic                      dir_wr,
  input logic                      inc,
  input logic [AW-1:0]             addr,
  input logic [(1<<AW)*(AW+2)-1:0] regs_o
);
  localparam int DW = AW + 2;
  localparam int FW = (1 << AW) * DW;

  logic [FW-1:0] keep_mask;
  assign keep_mask = ~(FW'({DW{1'b1}}) << (int'(WAKE_ADDR) * DW));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && in_data && inc) |=> (addr == AW'($past(addr) + 1'b1)));

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && in_data && !inc) |=> $stable(addr));

  assert_wake_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> pend);

  assert_regs_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_done && in_data && dir_wr) |=> ((regs_o & keep_mask) == $past(regs_o & keep_mask)));

  assert_miso_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n && $past(ss_n) && $past(ss_n, 2) && $past(ss_n, 3)) |-> !miso);
endmodule

bind spi_regfile spi_regfile_chk #(.AW(AW), .WAKE_ADDR(WAKE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .miso(miso), .wake_evt(wake_evt),
  .pend(pend), .byte_done(byte_done), .in_data(in_data), .dir_wr(dir_wr),
  .inc(inc), .addr(addr), .regs_o(regs_o)
);

// File: tb/sim_spi_regfile.sv
module sim_spi_regfile;
  localparam int HALF = 8;
  localparam logic [7:0] ID = 8'hA5;
  localparam logic [5:0] WK = 6'h1D;

  logic clk = 0, rst_n = 0, sck = 0, mosi = 0, ss_n = 1, wake_evt = 0;
  logic miso;
  logic [511:0] regs_o;
  int tests = 0, fails = 0;

  logic [7:0] m_mem [64];
  logic       m_pend;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #5 clk = ~clk;

  spi_regfile u0 (.clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .ss_n(ss_n),
                  .miso(miso), .wake_evt(wake_evt), .regs_o(regs_o));

  function automatic logic [7:0] mrd(input logic [5:0] a);
    if (a == 6'h00) return ID;
    if (a == WK)    return {7'b0, m_pend};
    return m_mem[a];
  endfunction

  function automatic logic [511:0] mflat();
    logic [511:0] f;
    for (int i = 0; i < 64; i++) f[i*8 +: 8] = mrd(6'(i));
    return f;
  endfunction

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = b[i];
      wait_clk(HALF);
      r[i] = miso;
      sck = 1;
      wait_clk(HALF);
      sck = 0;
    end
  endtask

  task automatic xact(input bit wr, input bit incr, input logic [5:0] a, input int n);
    logic [7:0] r;
    ss_n = 0;
    wait_clk(4);
    send_bits({wr, incr, a}, 8, r);
    for (int k = 0; k < n; k++) begin
      send_bits(wr ? wbuf[k] : 8'h00, 8, r);
      rbuf[k] = r;
    end
    wait_clk(HALF);
    ss_n = 1;
    wait_clk(8);
  endtask

  task automatic run_model_check(input bit wr, input bit incr, input logic [5:0] a0, input int n, input string req);
    logic [5:0] a;
    a = a0;
    xact(wr, incr, a0, n);
    if (wr) begin
      for (int k = 0; k < n; k++) begin
        if (a != 6'h00 && a != WK) m_mem[a] = wbuf[k];
        a = a + 6'(incr);
      end
    end else begin
      for (int k = 0; k <= n; k++) begin
        if (k < n) check({req, " read data"}, 512'(rbuf[k]), 512'(mrd(a)));
        if (a == WK) m_pend = 1'b0;
        a = a + 6'(incr);
      end
    end
    check({req, " regs_o"}, regs_o, mflat());
  endtask

  task automatic pulse_wake();
    wake_evt = 1;
    wait_clk(1);
    wake_evt = 0;
    m_pend = 1;
    wait_clk(1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 64; i++) m_mem[i] = 8'h00;
    m_pend = 0;
    wait_clk(10);
    rst_n = 1;
    wait_clk(4);

    // R10 reset state, R7 identification byte
    check("R10 reset regs", regs_o, mflat());
    check("R4 miso idle", 512'(miso), 512'(0));

    // R2 R3 single write then single read, R4
    wbuf[0] = 8'h3C;
    run_model_check(1, 0, 6'h05, 1, "R3");
    run_model_check(0, 0, 6'h05, 1, "R4");

    // R5 burst write with increment across wrap, touching RO 0x00 (R7)
    for (int k = 0; k < 4; k++) wbuf[k] = 8'h90 + 8'(k);
    run_model_check(1, 1, 6'h3E, 4, "R5 wrap write");
    run_model_check(0, 1, 6'h3E, 4, "R5 wrap read");

    // R5 no increment: repeated writes to one address, last wins
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    run_model_check(1, 0, 6'h10, 3, "R5 hold write");
    run_model_check(0, 0, 6'h10, 3, "R5 hold read");

    // R7 write to wake location ignored; R8 set and read clear
    wbuf[0] = 8'hFF;
    run_model_check(1, 0, WK, 1, "R7 ro write");
    pulse_wake();
    check("R8 wake set", regs_o, mflat());
    run_model_check(0, 0, WK, 2, "R8 read clear");
    pulse_wake();
    run_model_check(0, 1, 6'h1C, 1, "R8 lookahead clear");

    // R9 partial data byte discarded
    ss_n = 0;
    wait_clk(4);
    send_bits({2'b10, 6'h05}, 8, r);
    send_bits(8'hE7, 4, r);
    wait_clk(HALF);
    ss_n = 1;
    wait_clk(8);
    check("R9 partial byte", regs_o, mflat());
    // R9 partial command byte then normal transaction (R6)
    ss_n = 0;
    wait_clk(4);
    send_bits(8'hC7, 3, r);
    wait_clk(HALF);
    ss_n = 1;
    wait_clk(8);
    run_model_check(0, 0, 6'h05, 1, "R6 after partial");

    // R6 long burst
    for (int k = 0; k < 16; k++) wbuf[k] = 8'($urandom());
    run_model_check(1, 1, 6'h20, 16, "R6 long write");
    run_model_check(0, 1, 6'h20, 16, "R6 long read");

    // R1 R2 random transactions
    for (int t = 0; t < 60; t++) begin
      bit wr, incr;
      logic [5:0] a;
      int n;
      wr   = 1'($urandom());
      incr = 1'($urandom());
      a    = 6'($urandom());
      n    = 1 + int'($urandom_range(5));
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom());
      if ($urandom_range(7) == 0) pulse_wake();
      run_model_check(wr, incr, a, n, "R1 random");
    end

    check("R4 miso idle end", 512'(miso), 512'(0));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule